// File: doc/BRIEF.md
# Two-Bank Mixed-Trigger Interrupt Controller

This block collects up to 64 interrupt lines into two banks of 32 and presents them to a processor through a small 32-bit register bus. Every line passes through a synchroniser. Most lines are edge-triggered: a rising edge sets a sticky event bit, and that bit stays set until software clears it. A fixed per-bank level mask marks a group of lines as level-triggered. For those lines the request follows the live input and no event is latched. A per-line enable gates both kinds into a pending set.

The block drives a single registered interrupt request. It also offers a readout of the number of the highest pending line, so a handler can find its source without scanning the banks. A secondary controller can be cascaded by wiring its request output to any one of the lines.

Each bank has four word registers in a 64-byte window. Software writes the enable register and confirms the write by reading it back. Software clears events by writing ones to the acknowledge register. It can read the synchronised line states at any time.

Top module: `dual_bank_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every enable bit and every event bit is 0, `irq_out` is 0 and `pend_num` shows the none code.
- R2: Byte address bits [5:4] select the bank: 2'b10 (offset 0x20) is the lower bank, holding lines 0 to 31, and 2'b01 (offset 0x10) is the upper bank, holding lines 32 to 63. Line n is bit n mod 32 of bank n/32. Bits [3:2] select the register: 0 is the event register (read-only), 1 is the enable register (read/write), 2 is the acknowledge register (write-only, reads 0) and 3 is the synchronised line state (read-only). Every other address reads 0 and ignores writes. All accesses are whole 32-bit words.
- R3: On an edge-type line, a rising edge of the synchronised input sets the line's event bit, even while the line is disabled.
- R4: Writing 1 to an acknowledge bit clears the matching event bit, and writing 0 leaves it unchanged. If a new edge arrives in the same cycle as the acknowledge, the event bit ends up set.
- R5: An event bit stays set after its input falls, until it is acknowledged.
- R6: The level mask is 0x1FF00000 (bits 20 to 28) in both banks, or 0x3FF00000 (bits 20 to 29) when `WIDE_LEVEL` is 1. A masked line's request follows its synchronised input, and its event bit is never set.
- R7: A bank's pending set is (event OR (line state AND level mask)) AND enable. A disabled line is never pending.
- R8: Enabling an edge-type line whose input is already high and whose event bit is clear does not make it pending. A later rising edge does.
- R9: The enable register reads back exactly the last value written to it.
- R10: `irq_out` is registered. It is 1 in the clock after any bit of either pending set is 1, and 0 in the clock after both pending sets are empty.
- R11: `pend_num` gives the number (0 to 63) of the highest-numbered pending line. The upper bank is checked before the lower bank.
- R12: When nothing is pending, `pend_num` is 7'h7F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 64 | Asynchronous interrupt lines; bit n is line n |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 6 | Byte address within the 64-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| irq_out | output | 1 | Registered combined interrupt request |
| pend_num | output | 7 | Highest pending line number, or 7'h7F for none |

## Verification
The assertions check, on every cycle, the properties that hold at all times. An event bit only falls after an acknowledge write to its own bank. Level-masked bits never appear in the event registers. `irq_out` follows the pending sets with a one-cycle delay. `pend_num` always names a pending bit with nothing pending above it, or the none code. An enable write always lands.

Other behaviours depend on a particular order of stimulus, and only the bench's scenarios show them:
- the address map, including the placement of the two banks;
- edge capture while a line is disabled;
- an edge that arrives in the same cycle as its acknowledge;
- the lack of a request when a line is enabled while its input is already high;
- the ordering of the priority readout between the banks.

// File: rtl/irqc_pkg.sv
// Package: shared constants, register selector type and helper functions
// for the two-bank interrupt controller.
// Assumes byte addresses inside a 64-byte window and whole-word accesses.
package irqc_pkg;

    localparam int LINES_PER_BANK = 32;
    localparam int NUM_BANKS      = 2;
    localparam int TOTAL_LINES    = LINES_PER_BANK * NUM_BANKS;
    localparam int LINE_IDX_W     = $clog2(TOTAL_LINES);
    localparam int NUM_W          = LINE_IDX_W + 1;
    localparam int ADDR_W         = 6;

    typedef enum logic [1:0] {
        SEL_EVENT  = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_ACK    = 2'd2,
        SEL_STATE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        logic     bank;
        reg_sel_e sel;
    } decode_t;

    // Level-trigger mask shared by both banks; the wide variant adds bit 29.
    function automatic logic [LINES_PER_BANK-1:0] level_mask_f(input bit wide);
        return wide ? 32'h3FF0_0000 : 32'h1FF0_0000;
    endfunction

    // Maps a byte address onto a bank and register; 0x20 group is lower bank.
    function automatic decode_t decode_f(input logic [ADDR_W-1:0] addr);
        decode_t d;
        d.sel = reg_sel_e'(addr[3:2]);
        case (addr[5:4])
            2'b10:   begin d.hit = 1'b1; d.bank = 1'b0; end
            2'b01:   begin d.hit = 1'b1; d.bank = 1'b1; end
            default: begin d.hit = 1'b0; d.bank = 1'b0; end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/irqc_sync.sv
// Module: multi-flop synchroniser for a vector of asynchronous lines.
// Assumes each bit is independent; no bus coherency is implied.
module irqc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int LAST = STAGES - 1;

    logic [W-1:0] chain [STAGES];

    // Shift the inputs through the flop chain, clearing on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[LAST];
endmodule

// File: rtl/irqc_bank.sv
// Module: one 32-line bank. It holds the synchronised line state, the sticky
// edge events, the enables and the pending set.
// Assumes the level mask is fixed at build time; masked lines never latch.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter logic [LINES_PER_BANK-1:0] LEVEL_MASK  = 32'h1FF0_0000,
    parameter int                        SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LINES_PER_BANK-1:0] line_in,
    input  logic                      en_wr,
    input  logic                      ack_wr,
    input  logic [LINES_PER_BANK-1:0] wdata,
    output logic [LINES_PER_BANK-1:0] evt_q,
    output logic [LINES_PER_BANK-1:0] en_q,
    output logic [LINES_PER_BANK-1:0] state,
    output logic [LINES_PER_BANK-1:0] pend
);
    localparam logic [LINES_PER_BANK-1:0] EDGE_MASK = ~LEVEL_MASK;

    logic [LINES_PER_BANK-1:0] prev_q;
    logic [LINES_PER_BANK-1:0] rise;
    logic [LINES_PER_BANK-1:0] clr;

    irqc_sync #(.W(LINES_PER_BANK), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_in),
        .q     (state)
    );

    // Keep the previous synchronised state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= state;
    end

    // Find new rising edges on edge-type lines, and the bits being acknowledged.
    always_comb begin
        rise = state & ~prev_q & EDGE_MASK;
        clr  = ack_wr ? wdata : '0;
    end

    // Update the sticky events: acknowledge clears, and a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_q & ~clr) | rise;
    end

    // Hold the enable register, loaded whole on a write.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_wr) en_q <= wdata;
    end

    // Merge events with the live level lines and gate them with the enables.
    always_comb begin
        pend = (evt_q | (state & LEVEL_MASK)) & en_q;
    end
endmodule

// File: rtl/irqc_regif.sv
// Module: register bus decode. It produces per-bank write strobes and the
// read-data multiplexer.
// Assumes single-cycle accesses; reads are combinational from register state.
module irqc_regif
    import irqc_pkg::*;
(
    input  logic                                     bus_en,
    input  logic                                     bus_wr,
    input  logic [ADDR_W-1:0]                        bus_addr,
    input  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] evt,
    input  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] en,
    input  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] state,
    output logic [NUM_BANKS-1:0]                     en_wr,
    output logic [NUM_BANKS-1:0]                     ack_wr,
    output logic [LINES_PER_BANK-1:0]                rdata
);
    decode_t dec;

    // Decode the address once for both the write and read paths.
    always_comb begin
        dec = decode_f(bus_addr);
    end

    // Raise a write strobe for the addressed bank and register.
    always_comb begin
        en_wr  = '0;
        ack_wr = '0;
        if (bus_en && bus_wr && dec.hit) begin
            if (dec.sel == SEL_ENABLE) en_wr[dec.bank]  = 1'b1;
            if (dec.sel == SEL_ACK)    ack_wr[dec.bank] = 1'b1;
        end
    end

    // Select the read data; the acknowledge register and unmapped addresses read 0.
    always_comb begin
        rdata = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_EVENT:  rdata = evt[dec.bank];
                SEL_ENABLE: rdata = en[dec.bank];
                SEL_STATE:  rdata = state[dec.bank];
                default:    rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irqc_prio.sv
// Module: highest-set-bit encoder over the concatenated pending vector.
// Assumes the upper bank occupies the high half, so it is checked first.
module irqc_prio
    import irqc_pkg::*;
(
    input  logic [TOTAL_LINES-1:0] pend,
    output logic [NUM_W-1:0]       num
);
    localparam logic [NUM_W-1:0] NONE = '1;

    // Scan upward so the highest pending index is the one left in num.
    always_comb begin
        num = NONE;
        for (int i = 0; i < TOTAL_LINES; i++) begin
            if (pend[i]) num = NUM_W'(i);
        end
    end
endmodule

// File: rtl/dual_bank_irq_ctrl.sv
// Module: top of the two-bank mixed-trigger interrupt controller.
// Instantiates one bank per 32 lines, the bus decode, the priority encoder
// and the registered combined request.
// Assumes irq_in is asynchronous, and that rst_n is synchronous to clk.
module dual_bank_irq_ctrl
    import irqc_pkg::*;
#(
    parameter bit WIDE_LEVEL  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [TOTAL_LINES-1:0]    irq_in,
    input  logic                      bus_en,
    input  logic                      bus_wr,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [LINES_PER_BANK-1:0] bus_wdata,
    output logic [LINES_PER_BANK-1:0] bus_rdata,
    output logic                      irq_out,
    output logic [NUM_W-1:0]          pend_num
);
    localparam logic [LINES_PER_BANK-1:0] LVL_MASK = level_mask_f(WIDE_LEVEL);

    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] evt_b;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] en_b;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] state_b;
    logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] pend_b;
    logic [NUM_BANKS-1:0]                     en_wr;
    logic [NUM_BANKS-1:0]                     ack_wr;
    logic [TOTAL_LINES-1:0]                   pend_all;
    logic [LINES_PER_BANK-1:0]                lvl_mask_w;
    logic                                     irq_q;

    assign lvl_mask_w = LVL_MASK;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        irqc_bank #(.LEVEL_MASK(LVL_MASK), .SYNC_STAGES(SYNC_STAGES)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .line_in (irq_in[b*LINES_PER_BANK +: LINES_PER_BANK]),
            .en_wr   (en_wr[b]),
            .ack_wr  (ack_wr[b]),
            .wdata   (bus_wdata),
            .evt_q   (evt_b[b]),
            .en_q    (en_b[b]),
            .state   (state_b[b]),
            .pend    (pend_b[b])
        );
    end

    irqc_regif u_regif (
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .evt      (evt_b),
        .en       (en_b),
        .state    (state_b),
        .en_wr    (en_wr),
        .ack_wr   (ack_wr),
        .rdata    (bus_rdata)
    );

    assign pend_all = pend_b;

    irqc_prio u_prio (
        .pend (pend_all),
        .num  (pend_num)
    );

    // Register the OR of all pending bits as the combined request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |pend_all;
    end

    assign irq_out = irq_q;
endmodule

// File: rtl/irqc_checker.sv
// Module: assertion checker for dual_bank_irq_ctrl, bound to the top below.
// Assumes it sees the top's bus inputs, its outputs and the per-bank state.
module irqc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_en,
    input logic        bus_wr,
    input logic [5:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [63:0] evt_all,
    input logic [63:0] en_all,
    input logic [63:0] pend_all,
    input logic [31:0] lvl_mask,
    input logic        irq_out,
    input logic [6:0]  pend_num
);
    logic ack_lo, ack_hi, enw_lo, enw_hi;

    // Independent decode of the write strobes, from the word address.
    always_comb begin
        ack_lo = bus_en && bus_wr && (bus_addr[5:2] == 4'hA);
        ack_hi = bus_en && bus_wr && (bus_addr[5:2] == 4'h6);
        enw_lo = bus_en && bus_wr && (bus_addr[5:2] == 4'h9);
        enw_hi = bus_en && bus_wr && (bus_addr[5:2] == 4'h5);
    end

    a_r5_lo_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_lo |=> ((evt_all[31:0] & $past(evt_all[31:0])) == $past(evt_all[31:0])));
    a_r5_hi_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_hi |=> ((evt_all[63:32] & $past(evt_all[63:32])) == $past(evt_all[63:32])));
    a_r6_no_level_event: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all & {lvl_mask, lvl_mask}) == 64'd0);
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all & ~en_all) == 64'd0);
    a_r9_lo_readback: assert property (@(posedge clk) disable iff (!rst_n)
        enw_lo |=> (en_all[31:0] == $past(bus_wdata)));
    a_r9_hi_readback: assert property (@(posedge clk) disable iff (!rst_n)
        enw_hi |=> (en_all[63:32] == $past(bus_wdata)));
    a_r10_irq_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all != 64'd0) |=> irq_out);
    a_r10_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all == 64'd0) |=> !irq_out);
    a_r11_highest: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all != 64'd0) |-> ((pend_all >> pend_num[5:0]) == 64'd1));
    a_r12_none_code: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all == 64'd0) |-> (pend_num == 7'h7F));
endmodule

bind dual_bank_irq_ctrl irqc_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_all   (evt_b),
    .en_all    (en_b),
    .pend_all  (pend_all),
    .lvl_mask  (lvl_mask_w),
    .irq_out   (irq_out),
    .pend_num  (pend_num)
);

// File: tb/tb_dual_bank_irq_ctrl.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_dual_bank_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] LO_EVT = 6'h20, LO_EN = 6'h24, LO_ACK = 6'h28, LO_ST = 6'h2C;
    localparam logic [5:0] HI_EVT = 6'h10, HI_EN = 6'h14, HI_ACK = 6'h18, HI_ST = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_in = '0;
    logic        bus_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [6:0]  pend_num;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_bank_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_en(bus_en), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .pend_num(pend_num)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic cleanup();
        irq_in = '0;
        wait_cycles(4);
        bus_write(LO_EN, 32'h0);
        bus_write(HI_EN, 32'h0);
        bus_write(LO_ACK, 32'hFFFF_FFFF);
        bus_write(HI_ACK, 32'hFFFF_FFFF);
        wait_cycles(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(LO_EN, d);  check("R1 lower enable", d, 32'h0);
        bus_read(HI_EN, d);  check("R1 upper enable", d, 32'h0);
        bus_read(LO_EVT, d); check("R1 lower event", d, 32'h0);
        bus_read(HI_EVT, d); check("R1 upper event", d, 32'h0);
        check("R1 irq_out", {31'd0, irq_out}, 32'h0);
        check("R12 none at reset", {25'd0, pend_num}, 32'h7F);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_write(HI_EN, 32'hA5A5_0F0F);
        bus_write(LO_EN, 32'h0000_0001);
        bus_read(HI_EN, d);  check("R9 upper readback", d, 32'hA5A5_0F0F);
        bus_read(LO_EN, d);  check("R2 lower separate", d, 32'h0000_0001);
        bus_read(HI_ACK, d); check("R2 ack reads zero", d, 32'h0);
        bus_write(6'h04, 32'hFFFF_FFFF);
        bus_read(6'h04, d);  check("R2 unmapped reads zero", d, 32'h0);
        bus_read(LO_EN, d);  check("R2 unmapped write ignored", d, 32'h0000_0001);
        irq_in[33] = 1'b1;
        wait_cycles(4);
        bus_read(HI_ST, d);  check("R2 upper state bit 1", d, 32'h0000_0002);
        bus_read(LO_ST, d);  check("R2 lower state clear", d, 32'h0);
        cleanup();
    endtask

    task automatic t_edge();
        logic [31:0] d;
        irq_in[3] = 1'b1;
        wait_cycles(5);
        bus_read(LO_EVT, d); check("R3 edge while disabled", d, 32'h0000_0008);
        check("R7 disabled not pending", {31'd0, irq_out}, 32'h0);
        irq_in[3] = 1'b0;
        wait_cycles(4);
        bus_read(LO_EVT, d); check("R5 event sticky", d, 32'h0000_0008);
        bus_write(LO_EN, 32'h0000_0008);
        wait_cycles(2);
        check("R10 irq raised", {31'd0, irq_out}, 32'h1);
        check("R11 num line 3", {25'd0, pend_num}, 32'd3);
        bus_write(LO_ACK, 32'h0);
        bus_read(LO_EVT, d); check("R4 zero ack no effect", d, 32'h0000_0008);
        bus_write(LO_ACK, 32'h0000_0008);
        wait_cycles(2);
        bus_read(LO_EVT, d); check("R4 ack clears", d, 32'h0);
        check("R10 irq dropped", {31'd0, irq_out}, 32'h0);
        cleanup();
    endtask

    task automatic t_level();
        logic [31:0] d;
        bus_write(LO_EN, 32'h0040_0000);
        irq_in[22] = 1'b1;
        wait_cycles(4);
        check("R6 level irq", {31'd0, irq_out}, 32'h1);
        check("R6 level num", {25'd0, pend_num}, 32'd22);
        bus_read(LO_EVT, d); check("R6 level not latched", d, 32'h0);
        bus_read(LO_ST, d);  check("R6 state shows level", d, 32'h0040_0000);
        irq_in[22] = 1'b0;
        wait_cycles(4);
        check("R6 level follows input", {31'd0, irq_out}, 32'h0);
        irq_in[29] = 1'b1;
        bus_write(LO_EN, 32'h2000_0000);
        wait_cycles(4);
        bus_read(LO_EVT, d); check("R6 bit29 edge by default", d, 32'h2000_0000);
        cleanup();
    endtask

    task automatic t_enable_high();
        logic [31:0] d;
        irq_in[5] = 1'b1;
        wait_cycles(5);
        bus_write(LO_ACK, 32'h0000_0020);
        bus_write(LO_EN, 32'h0000_0020);
        wait_cycles(3);
        check("R8 no request on enable", {31'd0, irq_out}, 32'h0);
        check("R8 num none", {25'd0, pend_num}, 32'h7F);
        irq_in[5] = 1'b0;
        wait_cycles(3);
        irq_in[5] = 1'b1;
        wait_cycles(5);
        check("R8 later edge requests", {31'd0, irq_out}, 32'h1);
        bus_read(LO_EVT, d); check("R8 later edge latched", d, 32'h0000_0020);
        cleanup();
    endtask

    task automatic t_priority();
        bus_write(LO_EN, 32'hFFFF_FFFF);
        bus_write(HI_EN, 32'hFFFF_FFFF);
        irq_in[10] = 1'b1;
        irq_in[40] = 1'b1;
        wait_cycles(5);
        check("R11 upper bank first", {25'd0, pend_num}, 32'd40);
        irq_in[63] = 1'b1;
        wait_cycles(5);
        check("R11 highest line 63", {25'd0, pend_num}, 32'd63);
        bus_write(HI_ACK, 32'hFFFF_FFFF);
        wait_cycles(1);
        check("R11 falls back to lower", {25'd0, pend_num}, 32'd10);
        bus_write(LO_ACK, 32'h0000_0400);
        wait_cycles(1);
        check("R12 none after acks", {25'd0, pend_num}, 32'h7F);
        cleanup();
    endtask

    task automatic t_collision();
        logic [31:0] d;
        @(negedge clk);
        irq_in[7] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = LO_ACK; bus_wdata = 32'h0000_0080;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
        bus_read(LO_EVT, d); check("R4 new edge beats ack", d, 32'h0000_0080);
        cleanup();
    endtask

    initial begin
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);
        t_reset();
        t_map();
        t_edge();
        t_level();
        t_enable_high();
        t_priority();
        t_collision();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule